// File: doc/BRIEF.md
# Core Instruction Execute Unit

This block carries out one instruction of a circular-memory battle machine once its two operands have been resolved. The scheduler hands it the opcode, the program counter, and each operand as either a literal value or an absolute memory address. The unit then fetches the memory words it needs through one single-port synchronous memory and writes back any result. It reports how the issuing process continues: it falls through, branches, skips one slot, spawns a second process, or dies.

A memory word packs, from most to least significant bit, a 4-bit opcode, two 2-bit mode fields, the A-field and the B-field. Each field is `AW = $clog2(CORE_SIZE)` bits wide. The execute unit only carries the mode bits along. All address and field arithmetic wraps modulo `CORE_SIZE`. The memory answers a read one cycle after the request (read data is registered). It keeps that data on its read port until the next read.

Top module: `instr_exec_unit`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `mem_re`, `mem_we`, `kill` and `spawn` are 0.
- R2: Opcode 1 (move) with a literal A sets only the B-field of the word at the B address to the A value. Other bits of that word keep their values. With an address A, the whole A word is copied to the B address. The result is PC+1.
- R3: Opcode 2 (add) with a literal A adds it to the B-field of the B word only. With an address A, the A word's A-field and B-field are added to the B word's A-field and B-field respectively. Opcode bits and mode bits of the B word keep their values. The result is PC+1.
- R4: Opcode 3 (subtract) acts like R3 but subtracts the A side from the B side.
- R5: Opcode 7 (compare) with a literal A compares that value with the B word's B-field. Otherwise it compares the full A and B words. If they are equal, the continuation is PC+2 (a skip); if not, it is PC+1.
- R6: Opcode 8 (less-than) compares the A value, or the B-field of the A word, with the B word's B-field as unsigned numbers. If the A side is smaller, it skips (PC+2); otherwise the result is PC+1.
- R7: Opcode 5 continues at the A value when the B-side B-field is zero. Opcode 6 continues there when that field is non-zero. Otherwise each continues at PC+1, and neither writes memory.
- R8: Opcode 9 decrements the B word's B-field modulo `CORE_SIZE` and writes the word back. When B is a literal, it decrements that literal and writes nothing. It continues at the A value if the decremented value is non-zero, otherwise at PC+1.
- R9: Opcode 4 continues at the A value. Opcode 10 continues at PC+1 and raises `spawn` with `spawn_pc` equal to the A value.
- R10: Opcode 0 and the unused codes 11 to 15 raise `kill` and neither write memory nor spawn.
- R11: A literal B operand supplies the B-side B-field for reads. When B is a literal, no instruction writes memory.
- R12: After an accepted `start`, `done` rises after 1 + N cycles, where N is the number of words read. The A word is read for opcodes 1, 2, 3, 7 and 8 when A is an address. The B word is read when B is an address, for opcodes 2, 3, 5, 6, 7, 8 and 9, and for opcode 1 with a literal A. `ready` is low from the cycle after `start` until `done`. A read and a write never share a cycle.
- R13: Every continuation, field sum, difference and decrement wraps modulo `CORE_SIZE`. For example, PC+2 from `CORE_SIZE-1` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin executing the presented instruction (taken when `ready`) |
| ready | output | 1 | Unit is idle and accepts `start` |
| instr_op | input | 4 | Opcode of the instruction |
| cur_pc | input | AW | Address of the executing instruction |
| a_is_lit | input | 1 | A operand is a literal value |
| a_value | input | AW | A literal or A absolute address |
| b_is_lit | input | 1 | B operand is a literal value |
| b_value | input | AW | B literal or B absolute address |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8+2*AW | Word to write |
| mem_rdata | input | 8+2*AW | Registered read data, one cycle after `mem_re` |
| done | output | 1 | Result valid this cycle |
| kill | output | 1 | Issuing process terminates |
| next_pc | output | AW | Continuation address of the issuing process |
| spawn | output | 1 | A new process is requested |
| spawn_pc | output | AW | Start address of the new process |

## Verification
The embedded assertions check the handshake, single-port, kill and range rules on every cycle. They confirm that an accepted start drops `ready`, that read and write never overlap, and that a kill result neither writes nor spawns. They also confirm that no write comes from a literal-B instruction and that a continuation address stays inside the core. The actual data results need the bench's scenarios: field-only versus whole-word updates, wrap-around sums and differences, skip and branch decisions, and the preserved opcode and mode bits. The bench also measures read count against the cycle at which `done` rises.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int OP_W   = 4;
  localparam int MODE_W = 2;

  localparam logic [OP_W-1:0] OP_HALT = 4'd0;
  localparam logic [OP_W-1:0] OP_MOVE = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD  = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd3;
  localparam logic [OP_W-1:0] OP_JUMP = 4'd4;
  localparam logic [OP_W-1:0] OP_JZ   = 4'd5;
  localparam logic [OP_W-1:0] OP_JNZ  = 4'd6;
  localparam logic [OP_W-1:0] OP_SEQ  = 4'd7;
  localparam logic [OP_W-1:0] OP_SLT  = 4'd8;
  localparam logic [OP_W-1:0] OP_DJNZ = 4'd9;
  localparam logic [OP_W-1:0] OP_FORK = 4'd10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_A  = 2'd1,
    ST_RD_B  = 2'd2,
    ST_EXEC  = 2'd3
  } exu_state_e;

endpackage

// File: rtl/exu_plan.sv
module exu_plan
  import exu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            a_lit,
  input  logic            b_lit,
  output logic            need_a,
  output logic            need_b,
  output logic            do_write
);

  logic a_word_op;
  logic b_word_op;
  logic wr_op;

  always_comb begin
    a_word_op = 1'b0;
    b_word_op = 1'b0;
    wr_op     = 1'b0;
    unique case (op)
      OP_MOVE: begin a_word_op = 1'b1; b_word_op = a_lit; wr_op = 1'b1; end
      OP_ADD,
      OP_SUB:  begin a_word_op = 1'b1; b_word_op = 1'b1;  wr_op = 1'b1; end
      OP_SEQ,
      OP_SLT:  begin a_word_op = 1'b1; b_word_op = 1'b1; end
      OP_JZ,
      OP_JNZ:  b_word_op = 1'b1;
      OP_DJNZ: begin b_word_op = 1'b1; wr_op = 1'b1; end
      default: ;
    endcase
    need_a   = a_word_op & ~a_lit;
    need_b   = b_word_op & ~b_lit;
    do_write = wr_op & ~b_lit;
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int CORE_SIZE = 8000,
  parameter int AW        = $clog2(CORE_SIZE),
  parameter int WW        = OP_W + 2 * MODE_W + 2 * AW
)(
  input  logic [OP_W-1:0] op,
  input  logic [AW-1:0]   pc,
  input  logic            a_lit,
  input  logic [AW-1:0]   a_val,
  input  logic            b_lit,
  input  logic [AW-1:0]   b_val,
  input  logic [WW-1:0]   a_word,
  input  logic [WW-1:0]   b_word,
  output logic [WW-1:0]   wr_word,
  output logic            kill,
  output logic [AW-1:0]   next_pc,
  output logic            spawn,
  output logic [AW-1:0]   spawn_pc
);

  localparam logic [AW:0] CS = CORE_SIZE[AW:0];

  function automatic logic [AW-1:0] madd(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= CS) s = s - CS;
    return s[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] msub(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW:0] s;
    if (x >= y) s = {1'b0, x} - {1'b0, y};
    else        s = {1'b0, x} + CS - {1'b0, y};
    return s[AW-1:0];
  endfunction

  logic [AW-1:0] a_af, a_bf, b_af, b_bf;
  logic [AW-1:0] b_side, a_side;
  logic [AW-1:0] pc_p1, pc_p2, dec_v;
  logic          equal_w;

  always_comb begin
    a_bf    = a_word[AW-1:0];
    a_af    = a_word[2*AW-1:AW];
    b_bf    = b_word[AW-1:0];
    b_af    = b_word[2*AW-1:AW];
    b_side  = b_lit ? b_val : b_bf;
    a_side  = a_lit ? a_val : a_bf;
    pc_p1   = madd(pc, {{(AW-1){1'b0}}, 1'b1});
    pc_p2   = madd(pc_p1, {{(AW-1){1'b0}}, 1'b1});
    dec_v   = msub(b_side, {{(AW-1){1'b0}}, 1'b1});
    if (a_lit)      equal_w = (a_val == b_side);
    else if (b_lit) equal_w = (a_bf == b_side);
    else            equal_w = (a_word == b_word);
  end

  always_comb begin
    wr_word  = b_word;
    kill     = 1'b0;
    next_pc  = pc_p1;
    spawn    = 1'b0;
    spawn_pc = a_val;
    unique case (op)
      OP_MOVE: begin
        if (a_lit) wr_word[AW-1:0] = a_val;
        else       wr_word = a_word;
      end
      OP_ADD: begin
        if (a_lit) wr_word[AW-1:0] = madd(b_bf, a_val);
        else begin
          wr_word[AW-1:0]    = madd(b_bf, a_bf);
          wr_word[2*AW-1:AW] = madd(b_af, a_af);
        end
      end
      OP_SUB: begin
        if (a_lit) wr_word[AW-1:0] = msub(b_bf, a_val);
        else begin
          wr_word[AW-1:0]    = msub(b_bf, a_bf);
          wr_word[2*AW-1:AW] = msub(b_af, a_af);
        end
      end
      OP_JUMP: next_pc = a_val;
      OP_JZ:   if (b_side == '0) next_pc = a_val;
      OP_JNZ:  if (b_side != '0) next_pc = a_val;
      OP_SEQ:  if (equal_w) next_pc = pc_p2;
      OP_SLT:  if (a_side < b_side) next_pc = pc_p2;
      OP_DJNZ: begin
        wr_word[AW-1:0] = dec_v;
        if (dec_v != '0) next_pc = a_val;
      end
      OP_FORK: spawn = 1'b1;
      default: kill = 1'b1;
    endcase
  end

endmodule

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
#(
  parameter int AW = 13,
  parameter int WW = 34
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          need_a_in,
  input  logic          need_b_in,
  input  logic          write_in,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic [WW-1:0] mem_rdata,
  output logic          ready,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [WW-1:0] a_word
);

  exu_state_e    state_q, state_d;
  logic          need_b_q, need_b_d;
  logic          write_q, write_d;
  logic [WW-1:0] a_hold_q, a_hold_d;
  logic          accept;

  assign accept = start & (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    need_b_d = need_b_q;
    write_d  = write_q;
    a_hold_d = a_hold_q;
    ready    = 1'b0;
    done     = 1'b0;
    mem_re   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = b_addr;
    unique case (state_q)
      ST_IDLE: begin
        ready = 1'b1;
        if (accept) begin
          need_b_d = need_b_in;
          write_d  = write_in;
          if (need_a_in)      state_d = ST_RD_A;
          else if (need_b_in) state_d = ST_RD_B;
          else                state_d = ST_EXEC;
        end
      end
      ST_RD_A: begin
        mem_re   = 1'b1;
        mem_addr = a_addr;
        state_d  = need_b_q ? ST_RD_B : ST_EXEC;
      end
      ST_RD_B: begin
        mem_re   = 1'b1;
        a_hold_d = mem_rdata;
        state_d  = ST_EXEC;
      end
      default: begin
        done    = 1'b1;
        mem_we  = write_q;
        state_d = ST_IDLE;
      end
    endcase
  end

  // A word: held copy when a B read followed, else the live read port
  assign a_word = need_b_q ? a_hold_q : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      need_b_q <= 1'b0;
      write_q  <= 1'b0;
      a_hold_q <= '0;
    end else begin
      state_q  <= state_d;
      need_b_q <= need_b_d;
      write_q  <= write_d;
      a_hold_q <= a_hold_d;
    end
  end

  assert_busy_after_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  assert_port_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  assert_write_only_at_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> done);

endmodule

// File: rtl/instr_exec_unit.sv
module instr_exec_unit
  import exu_pkg::*;
#(
  parameter int CORE_SIZE = 8000,
  localparam int AW = $clog2(CORE_SIZE),
  localparam int WW = OP_W + 2 * MODE_W + 2 * AW
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            ready,
  input  logic [OP_W-1:0] instr_op,
  input  logic [AW-1:0]   cur_pc,
  input  logic            a_is_lit,
  input  logic [AW-1:0]   a_value,
  input  logic            b_is_lit,
  input  logic [AW-1:0]   b_value,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_re,
  output logic            mem_we,
  output logic [WW-1:0]   mem_wdata,
  input  logic [WW-1:0]   mem_rdata,
  output logic            done,
  output logic            kill,
  output logic [AW-1:0]   next_pc,
  output logic            spawn,
  output logic [AW-1:0]   spawn_pc
);

  // reset: asserted asynchronously, deasserted on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operand capture with explicit clock enable
  logic [OP_W-1:0] op_q, op_d;
  logic [AW-1:0]   pc_q, pc_d, a_q, a_d, b_q, b_d;
  logic            a_lit_q, a_lit_d, b_lit_q, b_lit_d;
  logic            load_en;

  assign load_en = start & ready;

  always_comb begin
    op_d    = load_en ? instr_op : op_q;
    pc_d    = load_en ? cur_pc   : pc_q;
    a_d     = load_en ? a_value  : a_q;
    b_d     = load_en ? b_value  : b_q;
    a_lit_d = load_en ? a_is_lit : a_lit_q;
    b_lit_d = load_en ? b_is_lit : b_lit_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q    <= OP_HALT;
      pc_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      a_lit_q <= 1'b0;
      b_lit_q <= 1'b0;
    end else begin
      op_q    <= op_d;
      pc_q    <= pc_d;
      a_q     <= a_d;
      b_q     <= b_d;
      a_lit_q <= a_lit_d;
      b_lit_q <= b_lit_d;
    end
  end

  logic          need_a, need_b, do_write;
  logic [WW-1:0] a_word;
  logic          alu_kill, alu_spawn;

  exu_plan plan_i (
    .op       (instr_op),
    .a_lit    (a_is_lit),
    .b_lit    (b_is_lit),
    .need_a   (need_a),
    .need_b   (need_b),
    .do_write (do_write)
  );

  exu_ctrl #(.AW(AW), .WW(WW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .need_a_in (need_a),
    .need_b_in (need_b),
    .write_in  (do_write),
    .a_addr    (a_q),
    .b_addr    (b_q),
    .mem_rdata (mem_rdata),
    .ready     (ready),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .a_word    (a_word)
  );

  exu_alu #(.CORE_SIZE(CORE_SIZE), .AW(AW), .WW(WW)) alu_i (
    .op       (op_q),
    .pc       (pc_q),
    .a_lit    (a_lit_q),
    .a_val    (a_q),
    .b_lit    (b_lit_q),
    .b_val    (b_q),
    .a_word   (a_word),
    .b_word   (mem_rdata),
    .wr_word  (mem_wdata),
    .kill     (alu_kill),
    .next_pc  (next_pc),
    .spawn    (alu_spawn),
    .spawn_pc (spawn_pc)
  );

  assign kill  = done & alu_kill;
  assign spawn = done & alu_spawn;

  assert_kill_is_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    kill |-> (!mem_we && !spawn));

  assert_literal_b_no_write_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |-> (!b_lit_q && mem_addr == b_q));

  assert_pc_in_core_R13: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !kill) |-> (int'(next_pc) < CORE_SIZE));

endmodule

// File: tb/instr_exec_unit_tb_top.sv
`timescale 1ns/1ps
module instr_exec_unit_tb_top;

  localparam int CS = 64;
  localparam int AW = 6;
  localparam int WW = 8 + 2 * AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ready;
  logic [3:0]    instr_op = '0;
  logic [AW-1:0] cur_pc = '0, a_value = '0, b_value = '0;
  logic          a_is_lit = 1'b0, b_is_lit = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_re, mem_we;
  logic [WW-1:0] mem_wdata;
  logic [WW-1:0] mem_rdata = '0;
  logic          done, kill, spawn;
  logic [AW-1:0] next_pc, spawn_pc;

  always #5 clk = ~clk;

  instr_exec_unit #(.CORE_SIZE(CS)) dut_i (.*);

  logic [WW-1:0] mem [CS];
  logic [WW-1:0] snap [CS];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk(int op, int am, int bm, int af, int bf);
    return {op[3:0], am[1:0], bm[1:0], af[AW-1:0], bf[AW-1:0]};
  endfunction
  function automatic int fb(logic [WW-1:0] w); return int'(w[AW-1:0]); endfunction
  function automatic int fa(logic [WW-1:0] w); return int'(w[2*AW-1:AW]); endfunction
  function automatic logic [WW-1:0] setfields(logic [WW-1:0] w, int af, int bf);
    logic [WW-1:0] r;
    r = w;
    r[AW-1:0] = bf[AW-1:0];
    r[2*AW-1:AW] = af[AW-1:0];
    return r;
  endfunction

  // reference model results
  int e_next, e_reads, e_waddr;
  bit e_kill, e_spawn, e_wr;
  logic [WW-1:0] e_wword;

  task automatic model(int op, bit al, int av, bit bl, int bv, int pc);
    logic [WW-1:0] aw, bw;
    int bside, aside, d;
    bit eq;
    aw = snap[av]; bw = snap[bv];
    bside = bl ? bv : fb(bw);
    e_next = (pc + 1) % CS; e_kill = 0; e_spawn = 0; e_wr = 0; e_waddr = bv; e_wword = bw;
    e_reads = ((!al && (op inside {1, 2, 3, 7, 8})) ? 1 : 0) +
              ((!bl && ((op == 1 && al) || (op inside {2, 3, 5, 6, 7, 8, 9}))) ? 1 : 0);
    case (op)
      1: begin e_wr = !bl; e_wword = al ? setfields(bw, fa(bw), av) : aw; end
      2: begin e_wr = !bl;
         e_wword = al ? setfields(bw, fa(bw), (fb(bw) + av) % CS)
                      : setfields(bw, (fa(bw) + fa(aw)) % CS, (fb(bw) + fb(aw)) % CS); end
      3: begin e_wr = !bl;
         e_wword = al ? setfields(bw, fa(bw), (fb(bw) - av + CS) % CS)
                      : setfields(bw, (fa(bw) - fa(aw) + CS) % CS, (fb(bw) - fb(aw) + CS) % CS); end
      4: e_next = av;
      5: if (bside == 0) e_next = av;
      6: if (bside != 0) e_next = av;
      7: begin
         eq = al ? (av == bside) : (bl ? (fb(aw) == bv) : (aw == bw));
         if (eq) e_next = (pc + 2) % CS; end
      8: begin aside = al ? av : fb(aw); if (aside < bside) e_next = (pc + 2) % CS; end
      9: begin d = (bside + CS - 1) % CS; e_wr = !bl;
         e_wword = setfields(bw, fa(bw), d); if (d != 0) e_next = av; end
      10: begin e_spawn = 1; end
      default: e_kill = 1;
    endcase
  endtask

  task automatic run(int op, bit al, int av, bit bl, int bv, int pc, string req);
    int cyc;
    bit same;
    for (int i = 0; i < CS; i++) snap[i] = mem[i];
    model(op, al, av, bl, bv, pc);
    @(negedge clk);
    instr_op = op[3:0]; a_is_lit = al; a_value = av[AW-1:0];
    b_is_lit = bl; b_value = bv[AW-1:0]; cur_pc = pc[AW-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(!ready, {req, " R12 busy"}, ready, 0);
    while (!done && cyc < 10) begin @(negedge clk); cyc++; end
    chk(cyc == e_reads + 1, {req, " R12 latency"}, cyc, e_reads + 1);
    chk(kill == e_kill, {req, " R10 kill"}, kill, e_kill);
    if (!e_kill) chk(next_pc == e_next, {req, " next_pc"}, next_pc, e_next);
    chk(spawn == e_spawn, {req, " R9 spawn"}, spawn, e_spawn);
    if (e_spawn) chk(spawn_pc == av, {req, " R9 spawn_pc"}, spawn_pc, av);
    @(negedge clk);
    same = 1;
    for (int i = 0; i < CS; i++) begin
      if (e_wr && i == e_waddr) begin if (mem[i] !== e_wword) same = 0; end
      else if (mem[i] !== snap[i]) same = 0;
    end
    chk(same, {req, " R11 memory"}, e_wr ? longint'(mem[e_waddr]) : 0,
        e_wr ? longint'(e_wword) : 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        finished = 1;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < CS; i++) mem[i] = mk(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ready == 1 && done == 0 && mem_re == 0 && mem_we == 0 && kill == 0 && spawn == 0,
        "R1 reset", {ready, done, mem_re, mem_we, kill, spawn}, 6'b100000);

    // directed corners
    mem[10] = mk(3, 1, 2, 7, 9);
    run(1, 1, 33, 0, 10, 5, "R2 move literal");
    mem[11] = mk(2, 3, 0, 21, 22);
    run(1, 0, 11, 0, 12, 5, "R2 move word");
    mem[13] = mk(5, 2, 1, 4, 60);
    run(2, 1, 10, 0, 13, 0, "R3 R13 add literal wrap");
    mem[14] = mk(0, 0, 0, 50, 3); mem[15] = mk(6, 1, 1, 20, 62);
    run(2, 0, 14, 0, 15, 1, "R3 R13 add pair wrap");
    mem[16] = mk(1, 0, 2, 9, 3);
    run(3, 1, 5, 0, 16, 2, "R4 R13 sub literal wrap");
    mem[17] = mk(0, 0, 0, 10, 1); mem[18] = mk(7, 3, 3, 4, 40);
    run(3, 0, 17, 0, 18, 3, "R4 sub pair");
    mem[19] = mk(4, 1, 2, 8, 8); mem[20] = mk(4, 1, 2, 8, 8);
    run(7, 0, 19, 0, 20, 63, "R5 R13 compare equal wrap");
    mem[20] = mk(4, 1, 3, 8, 8);
    run(7, 0, 19, 0, 20, 4, "R5 compare modes differ");
    run(7, 1, 8, 0, 20, 62, "R5 compare literal");
    mem[21] = mk(0, 0, 0, 0, 7);
    run(8, 1, 5, 0, 21, 6, "R6 less-than skip");
    run(8, 1, 7, 0, 21, 6, "R6 less-than equal");
    mem[22] = mk(0, 0, 0, 0, 63);
    run(8, 0, 22, 0, 21, 6, "R6 less-than unsigned");
    mem[23] = mk(0, 0, 0, 0, 0);
    run(5, 1, 40, 0, 23, 7, "R7 jz taken");
    run(6, 1, 40, 0, 23, 7, "R7 jnz fall");
    run(6, 1, 41, 1, 3, 7, "R7 R11 jnz literal");
    mem[24] = mk(9, 2, 2, 5, 1);
    run(9, 1, 30, 0, 24, 8, "R8 decrement to zero");
    run(9, 1, 30, 0, 24, 8, "R8 R13 decrement wrap");
    run(9, 1, 31, 1, 1, 9, "R8 R11 literal decrement");
    run(4, 1, 50, 1, 0, 9, "R9 jump");
    run(10, 0, 51, 1, 0, 63, "R9 R13 spawn");
    run(0, 1, 0, 1, 0, 10, "R10 halt");
    run(13, 0, 3, 0, 4, 10, "R10 undefined op");
    run(1, 1, 12, 1, 24, 11, "R11 move literal B");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op, av, bv, pc;
      bit al, bl;
      if (n % 50 == 0)
        for (int i = 0; i < CS; i++)
          mem[i] = mk($urandom % 16, $urandom % 4, $urandom % 4, $urandom % CS, $urandom % 4 == 0 ? 0 : $urandom % CS);
      op = $urandom % 12; al = $urandom % 3 == 0; bl = $urandom % 4 == 0;
      av = $urandom % CS; bv = $urandom % CS; pc = $urandom % CS;
      if ($urandom % 4 == 0) mem[bv] = mem[av];
      run(op, al, av, bl, bv, pc, "R2 R3 R4 R5 R6 R7 R8 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule